// File: doc/BRIEF.md
# SD Host Command and Status Register Block

This block is the software-facing register file of an SD/MMC host controller. Software writes a 32-bit argument and then a command word. When the command word has its enable bit set, a small state machine hands the command to a serial line engine through a start pulse and waits for that engine's completion handshake. The outcome is recorded in sticky status flags. Software clears the flags by writing ones to a separate clear register, and a mask register gates them onto one interrupt line. A successful response is captured into four response words, together with the index of the received response.

The command word also carries a controller reset bit. Writing it starts an internal reset that lasts a fixed number of cycles. The bit reads back as 1 while the reset runs and returns to 0 by itself once it ends. The status register also shows two live card levels, card absent and write protect, and flags each change of the card-absent level. The serial line engine sits outside this block; only its handshake is modelled here.

State machine: `S_IDLE` (waiting for a command write), `S_ISSUE` (one cycle with the start pulse high), `S_WAIT` (waiting for engine done), and `S_SRST` (controller reset running). The transitions are:
- idle to issue on an accepted command;
- issue to wait unconditionally;
- wait to idle on engine done;
- any state to reset on a command write carrying the reset bit;
- reset to idle after `RST_CYCLES` cycles.

Register word offsets (byte address = 4 × word):

| Word | Register | Read value |
|------|----------|------------|
| 0 | command | bits 8:0 are the latched fields, bit 9 is busy, bit 10 is reset-running |
| 1 | argument | the stored argument |
| 2–5 | response 0–3 | the captured response words |
| 6 | response command | the received response index and application flag |
| 10 | status | the sticky flags and the two live card levels |
| 11 | clear | reads 0 |
| 12 | mask | the interrupt mask |

Every other word reads 0.

Top module: `sdh_cmd_regs`

## Requirements
- R1: After reset, the command, status, mask and response registers all read 0, `irq` is 0 and `eng_start` is 0.
- R2: A write to the command register with bit 9 (enable) set, while idle, raises `eng_start` for exactly one cycle. During that cycle `eng_index` carries bits 5:0 of the command word, `eng_need_rsp` carries bit 6, `eng_long_rsp` carries bit 7, `eng_app` carries bit 8, and `eng_arg` carries the argument register. A command write with bit 9 clear starts nothing.
- R3: A command write that arrives while a command is in flight is ignored: the in-flight fields do not change and no second start follows.
- R4: On engine done, status bit 6 (command sent) is set. A command without bit 6 (need-response) sets no other flag.
- R5: For a command with need-response set, engine done sets a second flag as well. On `eng_timeout` this is bit 2 (response timeout). Otherwise, on `eng_crc_err`, it is bit 0 (response CRC fail). Otherwise it is bit 4 (response CRC ok). Timeout takes priority over CRC error.
- R6: On a good long response (command bit 7 set), response word 0 receives `eng_rsp[127:96]`, word 1 receives `[95:64]`, word 2 receives `[63:32]` and word 3 receives `[31:0]`. On a good short response, word 0 receives `eng_rsp[31:0]` and words 1–3 keep their values. A timed-out or failed response leaves all four words unchanged.
- R7: After a good response, the response-command register reads `eng_rsp_index` in bits 5:0 and the issued command's application bit in bit 6.
- R8: Status bits 10:0 are sticky. Writing the clear register clears exactly the flags whose bits are 1, and bits written as 0 leave their flags unchanged.
- R9: If a flag is set in the same cycle as a clear write that targets it, the flag ends up set.
- R10: `irq` is high exactly when some status bit 10:0 and its mask bit are both 1. The mask uses the same bit layout as the status register.
- R11: Status bit 11 shows `card_absent` and bit 12 shows `write_prot` as live levels. Each change of `card_absent` sets sticky bit 10 (card change).
- R12: A command write with bit 10 set starts a controller reset from any state. Command bit 10 reads 1 for `RST_CYCLES` cycles and then 0. The reset clears all sticky flags, the response words and the response-command register, and no start pulse is issued while it runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_start | output | 1 | One-cycle command start pulse to the line engine |
| eng_index | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_need_rsp | output | 1 | Command expects a response |
| eng_long_rsp | output | 1 | Response is 136-bit (four words) |
| eng_app | output | 1 | Application-command tag |
| eng_done | input | 1 | Engine completion pulse |
| eng_timeout | input | 1 | Response timed out (valid with done) |
| eng_crc_err | input | 1 | Response CRC failed (valid with done) |
| eng_rsp | input | 128 | Response payload (valid with done) |
| eng_rsp_index | input | 6 | Index of the received response |
| card_absent | input | 1 | Card detect level, 1 means no card |
| write_prot | input | 1 | Write protect level |
| irq | output | 1 | Masked interrupt |

## Verification
The sticky status cell can receive a set request from the command state machine and a clear request from a bus write in the same clock cycle. The bench provokes this by raising `eng_done` in the same cycle as a clear-register write that targets the command-sent bit. The flag must still read 1 afterwards. A second overlap occurs when a reset or command write meets an in-flight command: a command write is applied while the machine is waiting, and the bench judges it by unchanged engine fields and a start count of exactly one.

// File: rtl/sdh_pkg.sv
`timescale 1ns/1ps
package sdh_pkg;
    localparam int BUS_W     = 32;
    localparam int RSP_WORDS = 4;
    localparam int FLAG_N    = 11;

    // status / clear / mask bit positions
    localparam int F_RSP_CRC_BAD  = 0;
    localparam int F_RSP_TMO      = 2;
    localparam int F_RSP_CRC_GOOD = 4;
    localparam int F_CMD_DONE     = 6;
    localparam int F_CARD_CHG     = 10;

    // command word bit positions
    localparam int C_NEED = 6;
    localparam int C_LONG = 7;
    localparam int C_APP  = 8;
    localparam int C_EN   = 9;
    localparam int C_SRST = 10;

    // word offsets
    localparam int A_CMD    = 0;
    localparam int A_ARG    = 1;
    localparam int A_RSP0   = 2;
    localparam int A_RSPCMD = 6;
    localparam int A_STATUS = 10;
    localparam int A_CLEAR  = 11;
    localparam int A_MASK   = 12;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_SRST} cmd_state_t;
endpackage

// File: rtl/sdh_cmd_fsm.sv
`timescale 1ns/1ps
module sdh_cmd_fsm
    import sdh_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_en_bit,
    input  logic              cmd_srst_bit,
    input  logic              need_rsp,
    input  logic              eng_done,
    input  logic              eng_timeout,
    input  logic              eng_crc_err,
    output logic              cmd_accept,
    output logic              eng_start,
    output logic              busy,
    output logic              srst_busy,
    output logic              capture,
    output logic [FLAG_N-1:0] set_vec
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    cmd_state_t       state, state_n;
    logic [CNT_W-1:0] cnt;
    logic             srst_req;

    assign srst_req = cmd_wr && cmd_srst_bit;

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (srst_req) state_n = S_SRST;
                     else if (cmd_accept) state_n = S_ISSUE;
            S_ISSUE: state_n = srst_req ? S_SRST : S_WAIT;
            S_WAIT:  if (srst_req) state_n = S_SRST;
                     else if (eng_done) state_n = S_IDLE;
            S_SRST:  if (cnt == CNT_LAST) state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (state != S_SRST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        cmd_accept = 1'b0;
        eng_start  = 1'b0;
        busy       = 1'b0;
        srst_busy  = 1'b0;
        capture    = 1'b0;
        set_vec    = '0;
        unique case (state)
            S_IDLE:  cmd_accept = cmd_wr && cmd_en_bit && !cmd_srst_bit;
            S_ISSUE: begin
                eng_start = 1'b1;
                busy      = 1'b1;
            end
            S_WAIT: begin
                busy = 1'b1;
                if (eng_done) begin
                    set_vec[F_CMD_DONE] = 1'b1;
                    if (need_rsp) begin
                        if (eng_timeout)      set_vec[F_RSP_TMO]      = 1'b1;
                        else if (eng_crc_err) set_vec[F_RSP_CRC_BAD]  = 1'b1;
                        else begin
                            set_vec[F_RSP_CRC_GOOD] = 1'b1;
                            capture                 = 1'b1;
                        end
                    end
                end
            end
            S_SRST:  srst_busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdh_status_bank.sv
`timescale 1ns/1ps
module sdh_status_bank
    import sdh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_bits,
    input  logic              mask_wr,
    input  logic [FLAG_N-1:0] mask_bits,
    input  logic              card_absent,
    output logic [FLAG_N-1:0] flags,
    output logic [FLAG_N-1:0] mask_q,
    output logic              irq
);
    logic              card_prev;
    logic [FLAG_N-1:0] set_all, clr_v;

    always_comb begin
        set_all             = set_vec;
        set_all[F_CARD_CHG] = set_vec[F_CARD_CHG] | (card_absent ^ card_prev);
        clr_v               = clr_wr ? clr_bits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags     <= '0;
            mask_q    <= '0;
            card_prev <= 1'b0;
        end else begin
            card_prev <= card_absent;
            flags     <= (srst ? '0 : (flags & ~clr_v)) | set_all;
            if (mask_wr) mask_q <= mask_bits;
        end
    end

    assign irq = |(flags & mask_q);
endmodule

// File: rtl/sdh_rsp_capture.sv
`timescale 1ns/1ps
module sdh_rsp_capture
    import sdh_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             srst,
    input  logic                             capture,
    input  logic                             long_rsp,
    input  logic                             app,
    input  logic [RSP_WORDS*BUS_W-1:0]       rsp_in,
    input  logic [5:0]                       idx_in,
    output logic [RSP_WORDS-1:0][BUS_W-1:0]  rsp_words,
    output logic [6:0]                       rsp_cmd
);
    for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
        logic [BUS_W-1:0] word_q;
        logic [BUS_W-1:0] long_src;
        logic             load;
        logic [BUS_W-1:0] src;
        assign long_src = rsp_in[(RSP_WORDS-1-i)*BUS_W +: BUS_W];
        if (i == 0) begin : g_first
            assign load = capture;
            assign src  = long_rsp ? long_src : rsp_in[BUS_W-1:0];
        end else begin : g_rest
            assign load = capture && long_rsp;
            assign src  = long_src;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    word_q <= '0;
            else if (srst) word_q <= '0;
            else if (load) word_q <= src;
        end
        assign rsp_words[i] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rsp_cmd <= '0;
        else if (srst)    rsp_cmd <= '0;
        else if (capture) rsp_cmd <= {app, idx_in};
    end
endmodule

// File: rtl/sdh_cmd_regs.sv
`timescale 1ns/1ps
module sdh_cmd_regs
    import sdh_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int RST_CYCLES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    output logic                       eng_start,
    output logic [5:0]                 eng_index,
    output logic [BUS_W-1:0]           eng_arg,
    output logic                       eng_need_rsp,
    output logic                       eng_long_rsp,
    output logic                       eng_app,
    input  logic                       eng_done,
    input  logic                       eng_timeout,
    input  logic                       eng_crc_err,
    input  logic [RSP_WORDS*BUS_W-1:0] eng_rsp,
    input  logic [5:0]                 eng_rsp_index,
    input  logic                       card_absent,
    input  logic                       write_prot,
    output logic                       irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]               idx;
    logic                           cmd_wr, arg_wr, clr_wr, mask_wr;
    logic                           cmd_accept, busy, srst_busy, capture;
    logic [FLAG_N-1:0]              set_vec, flags, mask_q;
    logic [8:0]                     cmd_q;
    logic [BUS_W-1:0]               arg_q;
    logic [RSP_WORDS-1:0][BUS_W-1:0] rsp_words;
    logic [6:0]                     rsp_cmd;
    logic                           unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:FLAG_N]};
    assign cmd_wr      = bus_wr && (idx == IDX_W'(A_CMD));
    assign arg_wr      = bus_wr && (idx == IDX_W'(A_ARG));
    assign clr_wr      = bus_wr && (idx == IDX_W'(A_CLEAR));
    assign mask_wr     = bus_wr && (idx == IDX_W'(A_MASK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            arg_q <= '0;
        end else begin
            if (cmd_accept) cmd_q <= bus_wdata[8:0];
            if (arg_wr)     arg_q <= bus_wdata;
        end
    end

    assign eng_index    = cmd_q[5:0];
    assign eng_need_rsp = cmd_q[C_NEED];
    assign eng_long_rsp = cmd_q[C_LONG];
    assign eng_app      = cmd_q[C_APP];
    assign eng_arg      = arg_q;

    sdh_cmd_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_en_bit(bus_wdata[C_EN]), .cmd_srst_bit(bus_wdata[C_SRST]),
        .need_rsp(cmd_q[C_NEED]), .eng_done(eng_done),
        .eng_timeout(eng_timeout), .eng_crc_err(eng_crc_err),
        .cmd_accept(cmd_accept), .eng_start(eng_start), .busy(busy),
        .srst_busy(srst_busy), .capture(capture), .set_vec(set_vec)
    );

    sdh_status_bank u_status (
        .clk(clk), .rst_n(rst_n), .srst(srst_busy), .set_vec(set_vec),
        .clr_wr(clr_wr), .clr_bits(bus_wdata[FLAG_N-1:0]),
        .mask_wr(mask_wr), .mask_bits(bus_wdata[FLAG_N-1:0]),
        .card_absent(card_absent), .flags(flags), .mask_q(mask_q), .irq(irq)
    );

    sdh_rsp_capture u_rsp (
        .clk(clk), .rst_n(rst_n), .srst(srst_busy), .capture(capture),
        .long_rsp(cmd_q[C_LONG]), .app(cmd_q[C_APP]),
        .rsp_in(eng_rsp), .idx_in(eng_rsp_index),
        .rsp_words(rsp_words), .rsp_cmd(rsp_cmd)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_W'(A_CMD):    bus_rdata = {21'b0, srst_busy, busy, cmd_q};
            IDX_W'(A_ARG):    bus_rdata = arg_q;
            IDX_W'(A_RSPCMD): bus_rdata = {25'b0, rsp_cmd};
            IDX_W'(A_STATUS): bus_rdata = {19'b0, write_prot, card_absent, flags};
            IDX_W'(A_MASK):   bus_rdata = {21'b0, mask_q};
            default:          bus_rdata = '0;
        endcase
        for (int i = 0; i < RSP_WORDS; i++)
            if (idx == IDX_W'(A_RSP0 + i)) bus_rdata = rsp_words[i];
    end
endmodule

module sdh_cmd_regs_chk
    import sdh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              eng_start,
    input logic              eng_done,
    input logic [5:0]        eng_index,
    input logic              busy,
    input logic              srst_busy,
    input logic              clr_wr,
    input logic [FLAG_N-1:0] flags,
    input logic [FLAG_N-1:0] mask_q,
    input logic              irq
);
    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R12
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> !eng_start);

    // R9
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_start && eng_done) |=> flags[F_CMD_DONE]);

    // R8
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && !srst_busy) |=> ((flags & $past(flags)) == $past(flags)));

    // R10
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    // R3
    inflight_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(eng_index)));
endmodule

bind sdh_cmd_regs sdh_cmd_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_done(eng_done),
    .eng_index(eng_index), .busy(busy), .srst_busy(srst_busy),
    .clr_wr(clr_wr), .flags(flags), .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_sdh_cmd_regs.sv
`timescale 1ns/1ps
module tb_sdh_cmd_regs;
    localparam int RSTC = 4;
    localparam logic [6:0] AD_CMD = 7'h00, AD_ARG = 7'h04, AD_RSP0 = 7'h08,
                           AD_RSP1 = 7'h0C, AD_RSP2 = 7'h10, AD_RSP3 = 7'h14,
                           AD_RSPC = 7'h18, AD_STAT = 7'h28, AD_CLR = 7'h2C,
                           AD_MASK = 7'h30;
    localparam logic [31:0] EN = 32'h200, NEED = 32'h40, LONG = 32'h80,
                            APP = 32'h100, SRST = 32'h400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic eng_start, eng_need_rsp, eng_long_rsp, eng_app, irq;
    logic [5:0] eng_index;
    logic [31:0] eng_arg;
    logic eng_done = 1'b0, eng_timeout = 1'b0, eng_crc_err = 1'b0;
    logic [127:0] eng_rsp = '0;
    logic [5:0] eng_rsp_index = '0;
    logic card_absent = 1'b0, write_prot = 1'b0;

    int checks = 0, fails = 0, starts = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    sdh_cmd_regs #(.ADDR_W(7), .RST_CYCLES(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_index(eng_index), .eng_arg(eng_arg), .eng_need_rsp(eng_need_rsp),
        .eng_long_rsp(eng_long_rsp), .eng_app(eng_app), .eng_done(eng_done),
        .eng_timeout(eng_timeout), .eng_crc_err(eng_crc_err), .eng_rsp(eng_rsp),
        .eng_rsp_index(eng_rsp_index), .card_absent(card_absent),
        .write_prot(write_prot), .irq(irq)
    );

    always @(posedge clk) if (eng_start) starts <= starts + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic respond(input logic tmo, input logic crc, input logic [127:0] r,
                           input logic [5:0] ix);
        eng_done = 1'b1; eng_timeout = tmo; eng_crc_err = crc;
        eng_rsp = r; eng_rsp_index = ix;
        @(negedge clk);
        eng_done = 1'b0; eng_timeout = 1'b0; eng_crc_err = 1'b0;
    endtask

    // issue a command and bring it to the waiting state
    task automatic issue(input logic [31:0] cw);
        wr(AD_CMD, cw);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd(AD_CMD, rv);  chk("R1 cmd", rv, 0);
        rd(AD_STAT, rv); chk("R1 status", rv, 0);
        rd(AD_MASK, rv); chk("R1 mask", rv, 0);
        rd(AD_RSP0, rv); chk("R1 rsp0", rv, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 start", {31'b0, eng_start}, 0);
    endtask

    task automatic t_short;
        int s0;
        wr(AD_ARG, 32'hA5A5_0001);
        s0 = starts;
        wr(AD_CMD, EN | NEED | 32'd17);
        chk("R2 start", {31'b0, eng_start}, 1);
        chk("R2 index", {26'b0, eng_index}, 17);
        chk("R2 arg", eng_arg, 32'hA5A5_0001);
        chk("R2 flags", {29'b0, eng_app, eng_long_rsp, eng_need_rsp}, 3'b001);
        @(negedge clk);
        chk("R2 pulse", {31'b0, eng_start}, 0);
        respond(0, 0, {32'h1, 32'h2, 32'h3, 32'hCAFE_0017}, 6'd17);
        rd(AD_STAT, rv); chk("R4 R5 short ok", rv, 32'h50);
        rd(AD_RSP0, rv); chk("R6 short rsp0", rv, 32'hCAFE_0017);
        rd(AD_RSP1, rv); chk("R6 short rsp1 kept", rv, 0);
        rd(AD_RSPC, rv); chk("R7 rspcmd short", rv, 17);
        chk("R2 one start", starts - s0, 1);
    endtask

    task automatic t_long;
        wr(AD_CLR, 32'h7FF);
        issue(EN | NEED | LONG | APP | 32'd41);
        respond(0, 0, {32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000}, 6'd41);
        rd(AD_STAT, rv); chk("R5 long ok", rv, 32'h50);
        rd(AD_RSP0, rv); chk("R6 long w0", rv, 32'hD3D3_0003);
        rd(AD_RSP1, rv); chk("R6 long w1", rv, 32'hC2C2_0002);
        rd(AD_RSP2, rv); chk("R6 long w2", rv, 32'hB1B1_0001);
        rd(AD_RSP3, rv); chk("R6 long w3", rv, 32'hA0A0_0000);
        rd(AD_RSPC, rv); chk("R7 rspcmd app", rv, 32'h69);
    endtask

    task automatic t_outcomes;
        wr(AD_CLR, 32'h7FF);
        issue(EN | 32'd5);
        chk("R2 no-rsp need bit", {31'b0, eng_need_rsp}, 0);
        respond(0, 0, '1, 6'd5);
        rd(AD_STAT, rv); chk("R4 no-rsp only sent", rv, 32'h40);
        wr(AD_CLR, 32'h7FF);
        issue(EN | NEED | 32'd8);
        respond(1, 1, '1, 6'd8);
        rd(AD_STAT, rv); chk("R5 timeout", rv, 32'h44);
        rd(AD_RSP0, rv); chk("R6 timeout keeps rsp", rv, 32'hD3D3_0003);
        wr(AD_CLR, 32'h7FF);
        issue(EN | NEED | 32'd9);
        respond(0, 1, '1, 6'd9);
        rd(AD_STAT, rv); chk("R5 crc fail", rv, 32'h41);
        rd(AD_RSPC, rv); chk("R7 kept on crc fail", rv, 32'h69);
    endtask

    task automatic t_no_enable;
        int s0;
        wr(AD_CLR, 32'h7FF);
        s0 = starts;
        wr(AD_CMD, NEED | 32'd3);
        repeat (3) @(negedge clk);
        chk("R2 no enable no start", starts - s0, 0);
        rd(AD_CMD, rv); chk("R2 no enable idle", rv & 32'h200, 0);
    endtask

    task automatic t_busy_ignore;
        int s0;
        wr(AD_CLR, 32'h7FF);
        s0 = starts;
        issue(EN | NEED | 32'd12);
        wr(AD_CMD, EN | NEED | 32'd30);
        chk("R3 index held", {26'b0, eng_index}, 12);
        respond(0, 0, 128'h77, 6'd12);
        repeat (3) @(negedge clk);
        chk("R3 single start", starts - s0, 1);
        rd(AD_RSPC, rv); chk("R3 rspcmd", rv, 12);
    endtask

    task automatic t_clear;
        rd(AD_STAT, rv); chk("R8 pre", rv, 32'h50);
        wr(AD_CLR, 32'h10);
        rd(AD_STAT, rv); chk("R8 partial clear", rv, 32'h40);
        wr(AD_CLR, 32'h0);
        rd(AD_STAT, rv); chk("R8 zero write", rv, 32'h40);
    endtask

    task automatic t_collide;
        wr(AD_CLR, 32'h7FF);
        issue(EN | 32'd2);
        bus_wr = 1'b1; bus_addr = AD_CLR; bus_wdata = 32'h40;
        eng_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_done = 1'b0;
        rd(AD_STAT, rv); chk("R9 set wins", rv, 32'h40);
    endtask

    task automatic t_irq;
        chk("R10 unmasked", {31'b0, irq}, 0);
        wr(AD_MASK, 32'h40);
        chk("R10 masked on", {31'b0, irq}, 1);
        rd(AD_MASK, rv); chk("R10 mask read", rv, 32'h40);
        wr(AD_MASK, 32'h10);
        chk("R10 other mask", {31'b0, irq}, 0);
        wr(AD_MASK, 32'h40);
        wr(AD_CLR, 32'h40);
        chk("R10 cleared", {31'b0, irq}, 0);
        wr(AD_MASK, 32'h0);
    endtask

    task automatic t_live;
        write_prot = 1'b1;
        rd(AD_STAT, rv); chk("R11 write protect", rv, 32'h1000);
        card_absent = 1'b1;
        @(negedge clk);
        rd(AD_STAT, rv); chk("R11 card change", rv, 32'h1C00);
        card_absent = 1'b0; write_prot = 1'b0;
        @(negedge clk);
        wr(AD_CLR, 32'h7FF);
        rd(AD_STAT, rv); chk("R11 back", rv, 0);
    endtask

    task automatic t_srst;
        issue(EN | NEED | 32'd1);
        respond(0, 0, 128'h1234, 6'd1);
        wr(AD_CMD, SRST);
        rd(AD_CMD, rv); chk("R12 busy bit", rv & SRST, SRST);
        repeat (RSTC - 1) @(negedge clk);
        rd(AD_CMD, rv); chk("R12 still busy", rv & SRST, SRST);
        @(negedge clk);
        rd(AD_CMD, rv); chk("R12 self clear", rv & SRST, 0);
        rd(AD_STAT, rv); chk("R12 flags cleared", rv, 0);
        rd(AD_RSP0, rv); chk("R12 rsp cleared", rv, 0);
        rd(AD_RSPC, rv); chk("R12 rspcmd cleared", rv, 0);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_long();
        t_outcomes();
        t_no_enable();
        t_busy_ignore();
        t_clear();
        t_collide();
        t_irq();
        t_live();
        t_srst();
        summary();
        $finish;
    end
endmodule